// File: doc/BRIEF.md
# Read-Strobe Delay Tap Window Calibrator

This block searches for the range of read-strobe delay settings over which a memory read pattern compares correctly, then places both byte-lane delay taps near the centre of that range. A search starts from a caller-supplied tap. It walks the tap upward one step per trial until a trial fails or the tap reaches a fixed ceiling. It then returns to the starting tap and walks downward until a trial fails or the tap reaches zero. Each trial asks an external pattern checker to compare memory contents, and the block waits for the verdict before moving on.

The compare interface is a request/acknowledge handshake and is the only place where the block waits on a neighbour. `cmp_req` rises to ask for one compare and stays high, whatever the delay, until `cmp_ack` is seen high on a clock edge. `cmp_fail` is sampled on that same edge. The checker may stall for as long as it likes. The request then drops for at least one cycle before the next compare is asked for. While idle, the block presents either the starting tap (before any search has completed) or the last calibrated pair on its tap outputs. `done` marks the cycle in which a fresh result first appears.

Top module: `tapcal_dqs`

## Requirements
- R1: After reset and until the first search completes, while no search is running, `tap0` and `tap1` both equal `init_tap`. After a search completes, while idle, they hold the calibrated pair and do not follow `init_tap`.
- R2: A `start` pulse seen while idle begins a search. The first compare is requested with both taps equal to `init_tap`. During a search, `tap0` and `tap1` carry the same trial value.
- R3: Each trial issues at most two compares. The second is issued only if the first passed, and the trial fails if either compare reports `cmp_fail` = 1.
- R4: `cmp_req` stays high until the edge on which `cmp_ack` is high, falls on the following cycle, and stays low for at least one cycle between compares. `cmp_req` is never high while idle.
- R5: A failed upward trial sets the upper bound to the trial value minus one (zero if the trial was zero). The downward sweep then restarts at `init_tap`.
- R6: A passing upward trial increments the tap only while it is below 32. A passing upward trial at 32 or above sets the upper bound to that value and turns the sweep downward, so no trial exceeds the larger of 32 and `init_tap`.
- R7: A failed downward trial sets the lower bound to the trial value plus one and ends the search.
- R8: A passing downward trial at tap 0 sets the lower bound to 0 and ends the search.
- R9: The result is `tap0` = floor((upper + lower) / 2) and `tap1` = `tap0` + 1 modulo 64.
- R10: `done` is high for exactly one cycle, in the first idle cycle that shows the new result.
- R11: `start` pulses that arrive during a search have no effect on its course or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search when idle |
| init_tap | input | 6 | Starting tap for the search |
| cmp_req | output | 1 | Compare request, held until acknowledged |
| cmp_ack | input | 1 | Compare verdict valid on this edge |
| cmp_fail | input | 1 | Compare mismatch, sampled with `cmp_ack` |
| tap0 | output | 6 | Delay tap for byte lane 0 |
| tap1 | output | 6 | Delay tap for byte lane 1 |
| done | output | 1 | One-cycle pulse when the result is applied |

## Verification
The hardest case to reach is a trial whose first compare passes and whose second fails. This is the only path in which a trial issues two compares and is still counted as failed. The bench's checker model reaches it by failing only the second compare at one chosen tap inside an otherwise wide passing window. A separate model of the search predicts the resulting upper bound and the exact number of compares. Other cases start the search outside the window, at tap 0 and above the ceiling, so that the bound floor, the immediate turn and the odd-sum truncation are each forced.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;
  typedef enum logic [1:0] {
    SR_IDLE   = 2'd0,
    SR_ISSUE  = 2'd1,
    SR_WAIT   = 2'd2,
    SR_FINISH = 2'd3
  } srch_state_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/tapcal_cmp_seq.sv
// Issues the compares of one trial and folds them into a single verdict.
module tapcal_cmp_seq #(
  parameter int PASSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cmp_ack,
  input  logic cmp_fail,
  output logic cmp_req,
  output logic res_vld,
  output logic res_fail
);
  localparam int CNT_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PASSES - 1);

  logic [CNT_W-1:0] pass_idx;
  logic             rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_req  <= 1'b0;
      rearm    <= 1'b0;
      pass_idx <= '0;
      res_vld  <= 1'b0;
      res_fail <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      if (go) begin
        cmp_req  <= 1'b1;
        pass_idx <= '0;
      end else if (rearm) begin
        cmp_req <= 1'b1;
        rearm   <= 1'b0;
      end else if (cmp_req && cmp_ack) begin
        cmp_req <= 1'b0;
        if (cmp_fail || pass_idx == LAST) begin
          res_vld  <= 1'b1;
          res_fail <= cmp_fail;
        end else begin
          pass_idx <= pass_idx + CNT_W'(1);
          rearm    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tapcal_search.sv
// Bidirectional edge search: upward from the start tap, then downward.
module tapcal_search
  import tapcal_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int TAP_CEIL = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] init_tap,
  input  logic             res_vld,
  input  logic             res_fail,
  output logic             go,
  output logic             busy,
  output logic             finish,
  output logic [TAP_W-1:0] trial,
  output logic [TAP_W:0]   upper,
  output logic [TAP_W:0]   lower
);
  localparam int BND_W = TAP_W + 1;
  localparam logic [TAP_W-1:0] CEIL_V = TAP_W'(TAP_CEIL);

  srch_state_e      state;
  sweep_dir_e       dir;
  logic [TAP_W-1:0] init_q;

  assign go     = (state == SR_ISSUE);
  assign busy   = (state != SR_IDLE);
  assign finish = (state == SR_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SR_IDLE;
      dir    <= DIR_UP;
      trial  <= '0;
      init_q <= '0;
      upper  <= '0;
      lower  <= '0;
    end else begin
      case (state)
        SR_IDLE: begin
          if (start) begin
            trial  <= init_tap;
            init_q <= init_tap;
            dir    <= DIR_UP;
            upper  <= '0;
            lower  <= '0;
            state  <= SR_ISSUE;
          end
        end
        SR_ISSUE: state <= SR_WAIT;
        SR_WAIT: begin
          if (res_vld) begin
            if (dir == DIR_UP) begin
              if (res_fail) begin
                upper <= (trial == '0) ? '0 : ({1'b0, trial} - BND_W'(1));
                trial <= init_q;
                dir   <= DIR_DOWN;
                state <= SR_ISSUE;
              end else if (trial < CEIL_V) begin
                trial <= trial + TAP_W'(1);
                state <= SR_ISSUE;
              end else begin
                upper <= {1'b0, trial};
                trial <= init_q;
                dir   <= DIR_DOWN;
                state <= SR_ISSUE;
              end
            end else begin
              if (res_fail) begin
                lower <= {1'b0, trial} + BND_W'(1);
                state <= SR_FINISH;
              end else if (trial == '0) begin
                lower <= '0;
                state <= SR_FINISH;
              end else begin
                trial <= trial - TAP_W'(1);
                state <= SR_ISSUE;
              end
            end
          end
        end
        SR_FINISH: state <= SR_IDLE;
        default:   state <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tapcal_centre.sv
// Midpoint of the window and the tap output selection.
module tapcal_centre #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             finish,
  input  logic [TAP_W-1:0] trial,
  input  logic [TAP_W:0]   upper,
  input  logic [TAP_W:0]   lower,
  input  logic [TAP_W-1:0] init_tap,
  output logic [TAP_W-1:0] tap0,
  output logic [TAP_W-1:0] tap1,
  output logic             done
);
  localparam int SUM_W = TAP_W + 2;

  logic [SUM_W-1:0] sum;
  logic [TAP_W-1:0] mid;
  logic [TAP_W-1:0] res0, res1;
  logic             have_res;

  assign sum = {1'b0, upper} + {1'b0, lower};
  assign mid = TAP_W'(sum >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res0     <= '0;
      res1     <= '0;
      have_res <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        res0     <= mid;
        res1     <= mid + TAP_W'(1);
        have_res <= 1'b1;
      end
    end
  end

  always_comb begin
    if (busy) begin
      tap0 = trial;
      tap1 = trial;
    end else if (have_res) begin
      tap0 = res0;
      tap1 = res1;
    end else begin
      tap0 = init_tap;
      tap1 = init_tap;
    end
  end
endmodule

// File: rtl/tapcal_dqs.sv
module tapcal_dqs #(
  parameter int TAP_W    = 6,
  parameter int TAP_CEIL = 32,
  parameter int PASSES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] init_tap,
  output logic             cmp_req,
  input  logic             cmp_ack,
  input  logic             cmp_fail,
  output logic [TAP_W-1:0] tap0,
  output logic [TAP_W-1:0] tap1,
  output logic             done
);
  logic             go, busy, finish, res_vld, res_fail;
  logic [TAP_W-1:0] trial;
  logic [TAP_W:0]   upper, lower;

  tapcal_search #(.TAP_W(TAP_W), .TAP_CEIL(TAP_CEIL)) u_search (
    .clk(clk), .rst_n(rst_n), .start(start), .init_tap(init_tap),
    .res_vld(res_vld), .res_fail(res_fail), .go(go), .busy(busy),
    .finish(finish), .trial(trial), .upper(upper), .lower(lower)
  );

  tapcal_cmp_seq #(.PASSES(PASSES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cmp_ack(cmp_ack),
    .cmp_fail(cmp_fail), .cmp_req(cmp_req), .res_vld(res_vld),
    .res_fail(res_fail)
  );

  tapcal_centre #(.TAP_W(TAP_W)) u_centre (
    .clk(clk), .rst_n(rst_n), .busy(busy), .finish(finish),
    .trial(trial), .upper(upper), .lower(lower), .init_tap(init_tap),
    .tap0(tap0), .tap1(tap1), .done(done)
  );
endmodule

// File: rtl/tapcal_dqs_chk.sv
module tapcal_dqs_chk #(
  parameter int TAP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             cmp_req,
  input logic             cmp_ack,
  input logic [TAP_W-1:0] tap0,
  input logic [TAP_W-1:0] tap1,
  input logic             done
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req && !cmp_ack |=> cmp_req); // R4
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req && cmp_ack |=> !cmp_req); // R4
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmp_req); // R4
  AST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> tap0 == tap1); // R2
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R2
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R10
  AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tap1 == tap0 + TAP_W'(1)); // R9
endmodule

bind tapcal_dqs tapcal_dqs_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .cmp_req(cmp_req), .cmp_ack(cmp_ack), .tap0(tap0), .tap1(tap1),
  .done(done)
);

// File: tb/tapcal_dqs_test.sv
module tapcal_dqs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] init_tap = 6'd5;
  logic       cmp_req;
  logic       cmp_ack = 1'b0;
  logic       cmp_fail = 1'b0;
  logic [5:0] tap0, tap1;
  logic       done;

  always #2.5 clk = ~clk;

  tapcal_dqs uut (
    .clk(clk), .rst_n(rst_n), .start(start), .init_tap(init_tap),
    .cmp_req(cmp_req), .cmp_ack(cmp_ack), .cmp_fail(cmp_fail),
    .tap0(tap0), .tap1(tap1), .done(done)
  );

  typedef struct {
    int t0;
    int t1;
    int n;
  } exp_t;

  exp_t sb[$];
  int tests = 0, fails = 0;
  int win_lo = 0, win_hi = 63, glitch = -1;
  int req_count = 0, base = 0, first_tap = -1, max_tap = 0, runs_done = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Checker model: fails outside the window; at the glitch tap only the
  // second compare of a trial fails.
  initial begin
    int  wait_cnt = 0;
    bit  served = 0;
    int  last_tap = -1, last_idx = 1;
    bit  last_ok = 0;
    forever begin
      @(negedge clk);
      if (!cmp_req) served = 0;
      if (cmp_ack) begin
        cmp_ack  = 0;
        cmp_fail = 0;
      end else if (cmp_req && !served) begin
        wait_cnt++;
        if (wait_cnt == 3) begin
          int idx;
          int t;
          bit f;
          t   = int'(tap0);
          idx = (t == last_tap && last_ok && last_idx == 0) ? 1 : 0;
          f   = (t < win_lo) || (t > win_hi) || (idx == 1 && t == glitch);
          chk(tap0 == tap1, "R2 lanes equal during compare", int'(tap1), t);
          if (first_tap < 0) first_tap = t;
          if (t > max_tap) max_tap = t;
          last_tap = t; last_idx = idx; last_ok = !f;
          cmp_fail = f;
          cmp_ack  = 1;
          served   = 1;
          wait_cnt = 0;
          req_count++;
        end
      end
    end
  end

  // Monitor: pops the prediction when a result is announced.
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(tap0) == e.t0, "R9 tap0 midpoint", int'(tap0), e.t0);
          chk(int'(tap1) == e.t1, "R9 tap1 midpoint+1", int'(tap1), e.t1);
          chk(req_count - base == e.n, "R3 compare count", req_count - base, e.n);
        end
        @(negedge clk);
        chk(!done, "R10 done one cycle", int'(done), 0);
        runs_done++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10 watchdog expired", 0, 1);
    wrap_up();
  end

  int last_t0, last_t1;

  task automatic run_case(string name, int init, int lo, int hi, int gl, bit poke);
    exp_t e;
    int t = init, upper = 0, lower = 0, n = 0, target;
    bit up = 1;
    forever begin
      bit f;
      bit outside;
      outside = (t < lo) || (t > hi);
      f = outside || (t == gl);
      n += outside ? 1 : 2;
      if (up) begin
        if (f) begin upper = (t == 0) ? 0 : t - 1; t = init; up = 0; end
        else if (t < 32) t++;
        else begin upper = t; t = init; up = 0; end
      end else begin
        if (f) begin lower = t + 1; break; end
        else if (t == 0) begin lower = 0; break; end
        else t--;
      end
    end
    e.t0 = (upper + lower) / 2;
    e.t1 = (e.t0 + 1) % 64;
    e.n  = n;
    last_t0 = e.t0; last_t1 = e.t1;
    sb.push_back(e);
    win_lo = lo; win_hi = hi; glitch = gl;
    @(negedge clk);
    init_tap  = 6'(init);
    base      = req_count;
    first_tap = -1;
    max_tap   = 0;
    target    = runs_done + 1;
    start     = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1; init_tap = 6'(init + 9);
      @(negedge clk);
      start = 0;
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int i = 0; i < 20000 && runs_done < target; i++) @(negedge clk);
    chk(runs_done == target, {name, " completed"}, runs_done, target);
    chk(first_tap == init, {name, " R2 first trial at start tap"}, first_tap, init);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tap0 == 6'd5 && tap1 == 6'd5, "R1 reset taps follow init_tap", int'(tap0), 5);
    chk(!done && !cmp_req, "R4 reset idle outputs", int'(cmp_req), 0);
    rst_n = 1;
    @(negedge clk);
    init_tap = 6'd17;
    @(negedge clk);
    chk(tap1 == 6'd17, "R1 pre-search taps track init_tap", int'(tap1), 17);

    // Both edges found by failures: R5 upward fail, R7 downward fail.
    run_case("R5 R7 window 4..20", 10, 4, 20, -1, 0);
    // Ceiling reached and zero reached: R6 and R8.
    run_case("R6 R8 ceiling and floor", 25, 0, 40, -1, 0);
    chk(max_tap == 32, "R6 highest trial is the ceiling", max_tap, 32);
    // Start tap fails upward: R5 restart at the same tap.
    run_case("R5 start tap below window", 5, 10, 20, -1, 0);
    // Start tap 0 fails: upper floors at 0, lower 1.
    run_case("R5 R7 start at zero fails", 0, 10, 20, -1, 0);
    // Second compare fails only: R3.
    run_case("R3 second compare fails", 10, 0, 63, 14, 0);
    // Start above ceiling: immediate turn, R6.
    run_case("R6 start above ceiling", 40, 0, 63, -1, 0);
    chk(max_tap == 40, "R6 no trial above start tap", max_tap, 40);
    // Odd sum truncation: upper 21 lower 0 -> 10.
    run_case("R9 odd sum truncates", 12, 0, 21, -1, 0);
    // Start pulses during the search are ignored: R11.
    run_case("R11 start during search", 10, 4, 20, -1, 1);

    // Result held while idle and init_tap changes: R1.
    init_tap = 6'd50;
    repeat (6) @(negedge clk);
    chk(int'(tap0) == last_t0, "R1 idle holds tap0", int'(tap0), last_t0);
    chk(int'(tap1) == last_t1, "R1 idle holds tap1", int'(tap1), last_t1);
    chk(!cmp_req, "R4 no request while idle", int'(cmp_req), 0);
    chk(sb.size() == 0, "R10 every result announced", sb.size(), 0);
    wrap_up();
  end
endmodule